// File: doc/BRIEF.md
# Floating-Point Divide Exception Flag Unit

This block takes two IEEE-754 single-precision operands, a dividend and a divisor, together with a two-bit rounding-mode code. It reports which IEEE exceptions dividing them would raise. It does not deliver the quotient. Its answer is a small flag vector placed in the low bits of a 32-bit destination word. Two extra indicator bits record that a denormal operand was treated as zero, or that a quotient too small for the normal range was flushed to zero. No status state is left behind: every answer depends only on the operation that produced it.

The operands enter through a valid/ready handshake. The unit has no output back-pressure. When a result is complete it pulses `done_o` for one cycle. The result register and `wr_en_o` follow the guard bit that was captured with the operation. A guard of 0 leaves the destination untouched, but the completion pulse still appears. Mantissas are divided by an iterative restoring divider that produces two quotient bits per cycle. The divider keeps 24 quotient bits, a guard bit and a sticky bit, and from these the unit decides inexact, overflow and underflow.

Top module: `fpdf_unit`

## Requirements
- R1: `in_ready_o` is 1 when idle. After an accepting edge k it is 0 until edge k+15 and is 1 again from then on, so the next operation can be accepted at edge k+16. A held `in_valid_i` while `in_ready_o` is 0 is not taken.
- R2: `done_o` is 1 for exactly one cycle, following edge k+17. `wr_en_o` is 1 in that same cycle exactly when the captured guard was 1.
- R3: `result_o` bit positions are bit0 divide-by-zero, bit1 inexact, bit2 underflow, bit3 overflow, bit4 invalid, bit5 input flushed, bit6 output flushed, and bits 31:7 are always 0.
- R4: `result_o` is written only when the captured guard is 1. Otherwise it keeps its previous value.
- R5: an operand whose exponent field is 0 and whose fraction is nonzero is treated as zero and sets bit5.
- R6: invalid (bit4) alone is raised for 0/0, for infinity/infinity, and for any signaling NaN operand (exponent 255, fraction nonzero, fraction bit 22 = 0). Signaling NaN takes precedence over every other case.
- R7: a quiet NaN operand (exponent 255, fraction bit 22 = 1), infinity over a finite value, a finite value over infinity, and zero over a nonzero value raise no exception flag.
- R8: a finite nonzero dividend over a zero divisor raises only divide-by-zero (bit0).
- R9: for finite normal operands, inexact (bit1) is set when the quotient does not fit exactly in 24 significant bits. An exact quotient raises nothing.
- R10: rounding-mode codes are 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity. A rounded biased exponent of 255 or more sets overflow and inexact (0x0a) in every mode.
- R11: a rounded biased exponent of 0 or less sets output-flushed, underflow and inexact (0x46). A biased exponent of exactly 1 raises nothing if the quotient is exact.
- R12: after reset, `result_o` is 0, `done_o` and `wr_en_o` are 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand set offered |
| in_ready_o | output | 1 | Unit can accept an operand set |
| a_i | input | 32 | Dividend, single precision |
| b_i | input | 32 | Divisor, single precision |
| rmode_i | input | 2 | Rounding-mode code |
| guard_i | input | 1 | Write permission for this operation |
| done_o | output | 1 | One-cycle completion strobe |
| wr_en_o | output | 1 | Destination write strobe (done and guard) |
| result_o | output | 32 | Destination word holding the flag vector |

## Verification
The hardest state to reach is the second operation entering at the edge on which the first one's quotient is being moved into the flag stage. A slip of one cycle there corrupts one result or the other. A directed sequence offers the second operand set at the first cycle `in_ready_o` returns high and checks both completions, 16 cycles apart. Exponent boundaries are reached with operand pairs chosen so that the biased quotient exponent lands exactly on 0, 1, 254 and 255. A guard-0 operation follows a guard-1 one so that the held destination value can be seen.

// File: rtl/fpdf_pkg.sv
package fpdf_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int MANT_W = FRAC_W + 1;
  localparam int QBITS  = MANT_W + 2;   // integer bit + 23 fraction + guard + extra
  localparam int REM_W  = MANT_W + 2;
  localparam int BIAS   = 127;
  localparam int FLAG_W = 7;

  // flag positions inside the destination word
  localparam int FB_DBZ = 0;
  localparam int FB_INX = 1;
  localparam int FB_UNF = 2;
  localparam int FB_OVF = 3;
  localparam int FB_INV = 4;
  localparam int FB_IFZ = 5;
  localparam int FB_OFZ = 6;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_POS  = 2'd2,
    RM_NEG  = 2'd3
  } rmode_e;

  typedef struct packed {
    logic              sign;
    logic              zero;    // true zero or flushed denormal
    logic              denorm;
    logic              inf;
    logic              nan;
    logic              snan;
    logic [EXP_W-1:0]  exp;
    logic [MANT_W-1:0] mant;    // hidden one included
  } opcls_t;
endpackage

// File: rtl/fpdf_classify.sv
module fpdf_classify
  import fpdf_pkg::*;
(
  input  logic [31:0] op_i,
  output opcls_t      cls_o
);
  logic exp_ones, exp_zero, frac_nz;

  always_comb begin
    exp_ones = &op_i[30:23];
    exp_zero = ~|op_i[30:23];
    frac_nz  = |op_i[22:0];
    cls_o.sign   = op_i[31];
    cls_o.zero   = exp_zero;
    cls_o.denorm = exp_zero & frac_nz;
    cls_o.inf    = exp_ones & ~frac_nz;
    cls_o.nan    = exp_ones & frac_nz;
    cls_o.snan   = exp_ones & frac_nz & ~op_i[22];
    cls_o.exp    = op_i[30:23];
    cls_o.mant   = {1'b1, op_i[22:0]};
  end
endmodule

// File: rtl/fpdf_mant_div.sv
module fpdf_mant_div
  import fpdf_pkg::*;
#(
  parameter int STEP_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [MANT_W-1:0] dvd_i,
  input  logic [MANT_W-1:0] dvs_i,
  output logic [QBITS-1:0]  quo_o,
  output logic              rem_nz_o
);
  logic [REM_W-1:0]  rem_q, rem_nx;
  logic [QBITS-1:0]  quo_q, quo_nx;
  logic [MANT_W-1:0] dvs_q;

  // restoring division, STEP_BITS quotient bits per cycle
  always_comb begin
    rem_nx = rem_q;
    quo_nx = quo_q;
    for (int i = 0; i < STEP_BITS; i++) begin
      if (rem_nx >= {2'b00, dvs_q}) begin
        rem_nx = rem_nx - {2'b00, dvs_q};
        quo_nx = {quo_nx[QBITS-2:0], 1'b1};
      end else begin
        quo_nx = {quo_nx[QBITS-2:0], 1'b0};
      end
      rem_nx = rem_nx << 1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load_i) begin
      rem_q <= {2'b00, dvd_i};
      quo_q <= '0;
      dvs_q <= dvs_i;
    end else if (step_i) begin
      rem_q <= rem_nx;
      quo_q <= quo_nx;
    end
  end

  assign quo_o    = quo_q;
  assign rem_nz_o = |rem_q;

  // R9
  rem_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dvs_q != '0) |-> (rem_q < {1'b0, dvs_q, 1'b0}));
endmodule

// File: rtl/fpdf_flag_gen.sv
module fpdf_flag_gen
  import fpdf_pkg::*;
(
  input  logic              special_i,
  input  logic [FLAG_W-1:0] spec_flags_i,
  input  logic              ifz_i,
  input  logic [QBITS-1:0]  quo_i,
  input  logic              rem_nz_i,
  input  logic signed [9:0] exp_i,
  input  logic              sign_i,
  input  logic [1:0]        rmode_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic              norm, grd, stk, up, carry;
  logic [MANT_W-1:0] mant;
  logic signed [9:0] e_n, e_r;

  always_comb begin
    norm = quo_i[QBITS-1];
    mant = norm ? quo_i[QBITS-1 -: MANT_W] : quo_i[QBITS-2 -: MANT_W];
    grd  = norm ? quo_i[1] : quo_i[0];
    stk  = rem_nz_i | (norm & quo_i[0]);
    case (rmode_e'(rmode_i))
      RM_NEAR: up = grd & (stk | mant[0]);
      RM_ZERO: up = 1'b0;
      RM_POS:  up = (grd | stk) & ~sign_i;
      default: up = (grd | stk) & sign_i;
    endcase
    carry = (&mant) & up;
    e_n   = norm ? exp_i : exp_i - 10'sd1;
    e_r   = carry ? e_n + 10'sd1 : e_n;

    flags_o = '0;
    if (special_i) begin
      flags_o = spec_flags_i;
    end else if (e_r >= 10'sd255) begin
      flags_o[FB_OVF] = 1'b1;
      flags_o[FB_INX] = 1'b1;
    end else if (e_r <= 10'sd0) begin
      flags_o[FB_UNF] = 1'b1;
      flags_o[FB_INX] = 1'b1;
      flags_o[FB_OFZ] = 1'b1;
    end else begin
      flags_o[FB_INX] = grd | stk;
    end
    flags_o[FB_IFZ] = flags_o[FB_IFZ] | ifz_i;
  end
endmodule

// File: rtl/fpdf_unit.sv
module fpdf_unit
  import fpdf_pkg::*;
#(
  parameter int ISSUE_GAP = 16,
  parameter int STEP_BITS = 2,
  parameter int RES_W     = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [31:0]      a_i,
  input  logic [31:0]      b_i,
  input  logic [1:0]       rmode_i,
  input  logic             guard_i,
  output logic             done_o,
  output logic             wr_en_o,
  output logic [RES_W-1:0] result_o
);
  localparam int NSTEPS = (QBITS + STEP_BITS - 1) / STEP_BITS;
  localparam int CNT_W  = $clog2(ISSUE_GAP + 1);

  // operand classification, one instance per operand
  logic [31:0] opnd [2];
  opcls_t      cls  [2];
  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  for (genvar gi = 0; gi < 2; gi++) begin : g_cls
    fpdf_classify u_cls (.op_i(opnd[gi]), .cls_o(cls[gi]));
  end

  // special-case decision, precedence top to bottom
  logic              sp_any;
  logic [FLAG_W-1:0] sp_flags;
  always_comb begin
    sp_any   = 1'b1;
    sp_flags = '0;
    if (cls[0].snan | cls[1].snan)      sp_flags[FB_INV] = 1'b1;
    else if (cls[0].nan | cls[1].nan)   sp_flags = '0;
    else if (cls[0].inf & cls[1].inf)   sp_flags[FB_INV] = 1'b1;
    else if (cls[0].zero & cls[1].zero) sp_flags[FB_INV] = 1'b1;
    else if (cls[0].inf)                sp_flags = '0;
    else if (cls[1].zero)               sp_flags[FB_DBZ] = 1'b1;
    else if (cls[1].inf | cls[0].zero)  sp_flags = '0;
    else                                sp_any = 1'b0;
  end

  // issue counter
  logic [CNT_W-1:0] cnt_q;
  logic             accept, cap, step;
  assign in_ready_o = (cnt_q == '0) || (cnt_q == CNT_W'(ISSUE_GAP));
  assign accept     = in_valid_i & in_ready_o;
  assign cap        = (cnt_q == CNT_W'(ISSUE_GAP));
  assign step       = (cnt_q != '0) && (cnt_q <= CNT_W'(NSTEPS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (accept)           cnt_q <= CNT_W'(1);
    else if (cap)              cnt_q <= '0;
    else if (cnt_q != '0)      cnt_q <= cnt_q + CNT_W'(1);
  end

  // operation registers
  logic              op_special, op_ifz, op_sign, op_guard;
  logic [FLAG_W-1:0] op_sflags;
  logic signed [9:0] op_exp;
  logic [1:0]        op_rm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_special <= 1'b0;
      op_ifz     <= 1'b0;
      op_sign    <= 1'b0;
      op_guard   <= 1'b0;
      op_sflags  <= '0;
      op_exp     <= '0;
      op_rm      <= '0;
    end else if (accept) begin
      op_special <= sp_any;
      op_ifz     <= cls[0].denorm | cls[1].denorm;
      op_sign    <= cls[0].sign ^ cls[1].sign;
      op_guard   <= guard_i;
      op_sflags  <= sp_flags;
      op_exp     <= $signed({2'b00, cls[0].exp}) - $signed({2'b00, cls[1].exp}) + 10'sd127;
      op_rm      <= rmode_i;
    end
  end

  logic [QBITS-1:0] dv_quo;
  logic             dv_rem_nz;

  fpdf_mant_div #(.STEP_BITS(STEP_BITS)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .step_i   (step),
    .dvd_i    (cls[0].mant),
    .dvs_i    (cls[1].mant),
    .quo_o    (dv_quo),
    .rem_nz_o (dv_rem_nz)
  );

  // flag stage
  logic              s1_vld, s1_special, s1_ifz, s1_sign, s1_guard, s1_rem_nz;
  logic [FLAG_W-1:0] s1_sflags, flags;
  logic signed [9:0] s1_exp;
  logic [1:0]        s1_rm;
  logic [QBITS-1:0]  s1_quo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld <= 1'b0; s1_special <= 1'b0; s1_ifz <= 1'b0; s1_sign <= 1'b0;
      s1_guard <= 1'b0; s1_rem_nz <= 1'b0; s1_sflags <= '0; s1_exp <= '0;
      s1_rm <= '0; s1_quo <= '0;
    end else begin
      s1_vld <= cap;
      if (cap) begin
        s1_special <= op_special;
        s1_ifz     <= op_ifz;
        s1_sign    <= op_sign;
        s1_guard   <= op_guard;
        s1_rem_nz  <= dv_rem_nz;
        s1_sflags  <= op_sflags;
        s1_exp     <= op_exp;
        s1_rm      <= op_rm;
        s1_quo     <= dv_quo;
      end
    end
  end

  fpdf_flag_gen u_flags (
    .special_i    (s1_special),
    .spec_flags_i (s1_sflags),
    .ifz_i        (s1_ifz),
    .quo_i        (s1_quo),
    .rem_nz_i     (s1_rem_nz),
    .exp_i        (s1_exp),
    .sign_i       (s1_sign),
    .rmode_i      (s1_rm),
    .flags_o      (flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      wr_en_o  <= 1'b0;
      result_o <= '0;
    end else begin
      done_o  <= s1_vld;
      wr_en_o <= s1_vld & s1_guard;
      if (s1_vld && s1_guard) result_o <= {{(RES_W-FLAG_W){1'b0}}, flags};
    end
  end

  // R1
  busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o);
  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R4
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> done_o);
  // R11
  ovf_unf_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(result_o[FB_OVF] && result_o[FB_UNF]));
  // R6
  inv_dbz_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(result_o[FB_INV] && result_o[FB_DBZ]));
endmodule

// File: tb/fpdf_unit_tb_top.sv
`timescale 1ns/1ps
module fpdf_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] a = '0, b = '0;
  logic [1:0]  rm = '0;
  logic        guard = 1'b0;
  logic        done, wr_en;
  logic [31:0] result;

  int errors = 0;
  int checks = 0;
  logic [31:0] held = '0;
  logic finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  fpdf_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .a_i(a), .b_i(b), .rmode_i(rm), .guard_i(guard),
    .done_o(done), .wr_en_o(wr_en), .result_o(result)
  );

  // {dividend, divisor, rounding code, expected flags}
  localparam int NV = 23;
  localparam logic [73:0] VECS [NV] = '{
    {32'h7f7fffff, 32'h3f800000, 2'd0, 8'h00},  // R9 exact max/1
    {32'h7f7fffff, 32'h3e000000, 2'd0, 8'h0a},  // R10 overflow nearest
    {32'h7f7fffff, 32'h3e000000, 2'd1, 8'h0a},  // R10 toward zero
    {32'h7f7fffff, 32'h3e000000, 2'd2, 8'h0a},  // R10 toward +inf
    {32'hff7fffff, 32'h3e000000, 2'd3, 8'h0a},  // R10 toward -inf, negative
    {32'h7f000000, 32'h3f000000, 2'd0, 8'h0a},  // R10 exponent exactly 255
    {32'h7f000000, 32'h3f800000, 2'd0, 8'h00},  // R10 exponent 254
    {32'h40400000, 32'h00400000, 2'd0, 8'h21},  // R5 R8 denormal divisor
    {32'h7f800000, 32'hff800000, 2'd0, 8'h10},  // R6 inf/inf
    {32'h00000000, 32'h80000000, 2'd0, 8'h10},  // R6 0/0
    {32'h7fa00000, 32'h3f800000, 2'd0, 8'h10},  // R6 signaling NaN
    {32'h7f800000, 32'h7fa00000, 2'd0, 8'h10},  // R6 sNaN over inf
    {32'h3f800000, 32'h7fc00000, 2'd0, 8'h00},  // R7 quiet NaN
    {32'h7f800000, 32'h3f800000, 2'd0, 8'h00},  // R7 inf/finite
    {32'h3f800000, 32'h7f800000, 2'd0, 8'h00},  // R7 finite/inf
    {32'h00000000, 32'h3f800000, 2'd0, 8'h00},  // R7 zero/finite
    {32'h7fc00000, 32'h00400000, 2'd0, 8'h20},  // R5 R7 qNaN with denormal
    {32'h3f800000, 32'h40400000, 2'd0, 8'h02},  // R9 one third
    {32'h40c00000, 32'h40000000, 2'd0, 8'h00},  // R9 exact 3
    {32'h00800000, 32'h40000000, 2'd0, 8'h46},  // R11 exponent 0
    {32'h00800000, 32'h3f800001, 2'd0, 8'h46},  // R11 normalisation shift to 0
    {32'h00800000, 32'h3f800000, 2'd0, 8'h00},  // R11 exponent 1 exact
    {32'hbf800000, 32'h00000000, 2'd0, 8'h01}   // R8 nonzero/zero
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R1 R2 R3 R4: issue one operation and follow it to completion
  task automatic run_op(input logic [31:0] va, input logic [31:0] vb,
                        input logic [1:0] vrm, input logic vg,
                        input logic [7:0] flags, input string tag);
    int rdy_bad = 0;
    int done_bad = 0;
    logic [31:0] res = '0;
    logic we = 1'b0;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    a = va; b = vb; rm = vrm; guard = vg; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i <= 17; i++) begin
      if (i > 0) @(negedge clk);
      if (in_ready !== (i >= 15)) rdy_bad++;
      if (done !== (i == 17)) done_bad++;
      if (i == 17) begin res = result; we = wr_en; end
    end
    check({"R1 ready timing ", tag}, 32'(rdy_bad), 32'd0);
    check({"R2 done timing ", tag}, 32'(done_bad), 32'd0);
    check({"R2 write strobe ", tag}, {31'd0, we}, {31'd0, vg});
    if (vg) held = {24'd0, flags};
    check({"R3 flags ", tag}, res, held);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 result", result, 32'd0);
    check("R12 done", {31'd0, done}, 32'd0);
    check("R12 ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 after release", {29'd0, done, wr_en, in_ready}, 32'd1);

    for (int v = 0; v < NV; v++)
      run_op(VECS[v][73:42], VECS[v][41:10], VECS[v][9:8], 1'b1, VECS[v][7:0],
             $sformatf("row %0d", v));

    // R4 guard low keeps destination
    run_op(32'h7f7fffff, 32'h3e000000, 2'd0, 1'b1, 8'h0a, "R4 guarded write");
    run_op(32'h7f800000, 32'hff800000, 2'd0, 1'b0, 8'h10, "R4 guard low");

    // R1 back-to-back issue at the first ready cycle
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    a = 32'h3f800000; b = 32'h40400000; rm = 2'd0; guard = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 1; i <= 15; i++) @(negedge clk);
    check("R1 ready at gap", {31'd0, in_ready}, 32'd1);
    a = 32'h7f800000; b = 32'hff800000; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 busy after second accept", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    check("R2 first done", {31'd0, done}, 32'd1);
    check("R9 first result", result, 32'h02);
    repeat (16) @(negedge clk);
    check("R2 second done", {31'd0, done}, 32'd1);
    check("R6 second result", result, 32'h10);

    // R1 held valid during busy is not taken: only one completion
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    a = 32'h3f800000; b = 32'h00000000; guard = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    a = 32'h3f800000; b = 32'h40400000;
    for (int i = 1; i <= 14; i++) @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 single completion", {31'd0, done}, 32'd1);
    check("R8 result", result, 32'h01);
    repeat (20) @(negedge clk);
    check("R1 no extra completion", result, 32'h01);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule